// File: doc/BRIEF.md
# Half-Buffer Notifying Output Sample FIFO

This block buffers raw output sample codes between a host that writes one sample at a time through a register port and a consumer that takes one sample per output tick, such as a converter update strobe. The host presents a data value and raises a new-data level. Each rising edge of that level stores exactly one sample. While output is enabled, every tick removes the oldest stored sample and holds it on the output until the next tick.

Samples are not managed through full or empty flags. The host treats the store as a logical buffer of two halves, which is smaller than the physical storage. It preloads both halves before enabling output. The block counts consumed samples and raises a sticky notification each time one half's worth has gone out. The host then writes one half of new samples and acknowledges. The spare physical entries absorb the host's refill latency.

Four error conditions are reported as sticky flags: a write to a full store, a tick with nothing stored, a half boundary reached while the previous notification is still pending, and the pending notification itself. A typical build has 8192 physical entries and a 4000-sample half, which gives an 8000-sample logical buffer. The parameter defaults are smaller so that elaboration stays light.

Top module: `halfbuf_out_fifo`

## Requirements
- R1: After reset, `fill_level` is 0, `out_sample` is 0, and `notify`, `missed`, `underflow` and `overflow` are all 0.
- R2: Each rising edge of `wr_new` stores `wr_data` as exactly one sample. Holding `wr_new` high for several cycles stores only one sample.
- R3: A write edge that arrives while `fill_level` equals DEPTH is dropped and leaves `fill_level` unchanged. If `out_en` is high, it also sets `overflow`, which then stays set.
- R4: With `out_en` high, a one-cycle `out_tick` on a non-empty store removes the oldest sample. That sample appears on `out_sample` at the next clock edge, and samples leave in write order. With `out_en` low, a tick changes neither `out_sample` nor `fill_level`.
- R5: With `out_en` high, `notify` sets on every HALF-th sample consumed since enable. It stays set until a one-cycle `notify_ack` pulse clears it.
- R6: If a half boundary is reached while `notify` is still set, `missed` sets and then stays set.
- R7: A tick with `out_en` high on an empty store keeps `out_sample` unchanged and sets `underflow`, which then stays set.
- R8: While `out_en` is low, the consumption counter and all four flags are held clear. The stored samples and `fill_level` are kept.
- R9: A one-cycle `flush` pulse empties the store. `fill_level` then reads 0, and the next enabled tick underflows.
- R10: `fill_level` equals the number of accepted writes minus the number of consumed samples, and stays within 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | DW | Sample code from the host register |
| wr_new | input | 1 | New-data level; a rising edge stores one sample |
| out_en | input | 1 | Enables consumption and the flags |
| out_tick | input | 1 | Output sample-rate strobe |
| flush | input | 1 | Empties the stored samples |
| notify_ack | input | 1 | Host acknowledge; clears `notify` |
| out_sample | output | DW | Most recently consumed sample |
| notify | output | 1 | Sticky half-buffer-consumed notification |
| missed | output | 1 | Sticky missed-notification flag |
| underflow | output | 1 | Sticky tick-on-empty flag |
| overflow | output | 1 | Sticky write-on-full flag |
| fill_level | output | $clog2(DEPTH+1) | Number of stored samples |

## Verification
The bench builds the block with DEPTH of 16 and HALF of 6. This gives a 12-sample logical buffer with 4 entries of headroom. With these values, filling the store to the physical limit, crossing three half boundaries and reaching a boundary with a pending notification each take only a few dozen host writes and ticks. The bench also disables output part way through a half. This shows that the counter restarts from zero on the next enable and does not carry the earlier partial count.

// File: rtl/halfbuf_pkg.sv
package halfbuf_pkg;

  // Increment with wrap to zero when the limit is reached.
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v + 32'd1 >= lim) ? 32'd0 : v + 32'd1;
  endfunction

  // True when the value sits on the last step before wrapping.
  function automatic logic at_wrap(input logic [31:0] v, input logic [31:0] lim);
    return (v + 32'd1 >= lim);
  endfunction

  // Occupancy after one cycle of pushes and pops.
  function automatic logic [31:0] level_next(input logic [31:0] lvl, input logic push, input logic pop);
    return lvl + {31'b0, push} - {31'b0, pop};
  endfunction

endpackage

// File: rtl/hbf_store.sv
module hbf_store
  import halfbuf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign rdata = mem[rd_ptr];
  assign full  = (32'(level) == DEPTH);
  assign empty = (level == '0);

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= AW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(wrap_inc(32'(rd_ptr), DEPTH));
      level <= LW'(level_next(32'(level), push, pop));
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH); // R10
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !push && !pop) |=> $stable(level)); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R9

endmodule

// File: rtl/hbf_wr_gate.sv
module hbf_wr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_new,
  input  logic en,
  input  logic full,
  output logic push,
  output logic overflow
);

  logic wr_new_q;
  logic wr_edge;
  logic drop_evt;

  assign wr_edge  = wr_new && !wr_new_q;
  assign push     = wr_edge && !full;
  assign drop_evt = wr_edge && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_new_q <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wr_new_q <= wr_new;
      if (!en)           overflow <= 1'b0;
      else if (drop_evt) overflow <= 1'b1;
    end
  end

  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && en) |=> overflow); // R3
  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R3

endmodule

// File: rtl/hbf_consume.sv
module hbf_consume
  import halfbuf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int HALF = 1000,
  localparam int CW  = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          notify_ack,
  input  logic          empty,
  input  logic [DW-1:0] rdata,
  output logic          pop,
  output logic [DW-1:0] out_sample,
  output logic          notify,
  output logic          missed,
  output logic          underflow
);

  logic [CW-1:0] cnt;
  logic          boundary_evt;
  logic          starve_evt;

  assign pop          = en && tick && !empty;
  assign starve_evt   = en && tick && empty;
  assign boundary_evt = pop && at_wrap(32'(cnt), HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      out_sample <= '0;
      notify     <= 1'b0;
      missed     <= 1'b0;
      underflow  <= 1'b0;
    end else begin
      if (pop) out_sample <= rdata;
      if (!en) begin
        cnt       <= '0;
        notify    <= 1'b0;
        missed    <= 1'b0;
        underflow <= 1'b0;
      end else begin
        if (pop) cnt <= CW'(wrap_inc(32'(cnt), HALF));
        if (boundary_evt)    notify <= 1'b1;
        else if (notify_ack) notify <= 1'b0;
        if (boundary_evt && notify && !notify_ack) missed <= 1'b1;
        if (starve_evt) underflow <= 1'b1;
      end
    end
  end

  AST_NOTIFY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_evt |=> notify); // R5
  AST_MISSED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_evt && notify && !notify_ack) |=> missed); // R6
  AST_STARVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    starve_evt |=> ($stable(out_sample) && underflow)); // R7
  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!notify && !missed && !underflow)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_sample)); // R4

endmodule

// File: rtl/halfbuf_out_fifo.sv
module halfbuf_out_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  parameter int HALF  = 1000,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_new,
  input  logic          out_en,
  input  logic          out_tick,
  input  logic          flush,
  input  logic          notify_ack,
  output logic [DW-1:0] out_sample,
  output logic          notify,
  output logic          missed,
  output logic          underflow,
  output logic          overflow,
  output logic [LW-1:0] fill_level
);

  logic          push, pop, full, empty;
  logic [DW-1:0] rdata;

  hbf_wr_gate u_wr (
    .clk(clk), .rst_n(rst_n), .wr_new(wr_new), .en(out_en),
    .full(full), .push(push), .overflow(overflow)
  );

  hbf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wdata(wr_data), .rdata(rdata), .level(fill_level),
    .full(full), .empty(empty)
  );

  hbf_consume #(.DW(DW), .HALF(HALF)) u_cons (
    .clk(clk), .rst_n(rst_n), .en(out_en), .tick(out_tick),
    .notify_ack(notify_ack), .empty(empty), .rdata(rdata), .pop(pop),
    .out_sample(out_sample), .notify(notify), .missed(missed),
    .underflow(underflow)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (fill_level == '0 && !notify && !missed && !underflow && !overflow)); // R1

endmodule

// File: tb/halfbuf_out_fifo_tb.sv
module halfbuf_out_fifo_tb;
  localparam int DW = 16, DEPTH = 16, HALF = 6;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_new = 0, out_en = 0, out_tick = 0, flush = 0, notify_ack = 0;
  logic [DW-1:0] out_sample;
  logic notify, missed, underflow, overflow;
  logic [LW-1:0] fill_level;

  int tests = 0, fails = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] last_out = '0;
  logic [DW-1:0] seq = 16'hA000;

  always #10 clk = ~clk;

  halfbuf_out_fifo #(.DW(DW), .DEPTH(DEPTH), .HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_new(wr_new),
    .out_en(out_en), .out_tick(out_tick), .flush(flush),
    .notify_ack(notify_ack), .out_sample(out_sample), .notify(notify),
    .missed(missed), .underflow(underflow), .overflow(overflow),
    .fill_level(fill_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_push(input int hold);
    @(negedge clk);
    wr_data = seq;
    wr_new = 1;
    for (int i = 0; i < hold; i++) @(negedge clk);
    wr_new = 0;
    if (mq.size() < DEPTH) mq.push_back(seq);
    seq++;
  endtask

  task automatic do_tick();
    @(negedge clk);
    out_tick = 1;
    @(negedge clk);
    out_tick = 0;
    if (out_en && mq.size() > 0) last_out = mq.pop_front();
    chk("R4 sample order", int'(out_sample), int'(last_out));
    chk("R10 level", int'(fill_level), mq.size());
  endtask

  task automatic do_ack();
    @(negedge clk);
    notify_ack = 1;
    @(negedge clk);
    notify_ack = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 fill", int'(fill_level), 0);
    chk("R1 sample", int'(out_sample), 0);
    chk("R1 flags", int'({notify, missed, underflow, overflow}), 0);
  endtask

  task automatic t_preload();
    for (int i = 0; i < 2 * HALF; i++) do_push(1);
    chk("R2 preload fill", int'(fill_level), 2 * HALF);
    do_push(3);
    chk("R2 held level pushes once", int'(fill_level), 2 * HALF + 1);
  endtask

  task automatic t_overflow();
    out_en = 1;
    while (mq.size() < DEPTH) do_push(1);
    chk("R3 full level", int'(fill_level), DEPTH);
    chk("R3 no overflow yet", int'(overflow), 0);
    do_push(1);
    chk("R3 overflow set", int'(overflow), 1);
    chk("R3 fill unchanged", int'(fill_level), DEPTH);
  endtask

  task automatic t_notify();
    for (int i = 0; i < HALF - 1; i++) do_tick();
    chk("R5 no notify early", int'(notify), 0);
    do_tick();
    chk("R5 notify at half", int'(notify), 1);
    do_ack();
    chk("R5 ack clears", int'(notify), 0);
    for (int i = 0; i < HALF; i++) do_tick();
    chk("R5 notify second half", int'(notify), 1);
    chk("R6 not missed yet", int'(missed), 0);
  endtask

  task automatic t_missed();
    while (mq.size() > 0) do_tick();
    do_push(1);
    do_push(1);
    do_tick();
    do_tick();
    chk("R6 missed set", int'(missed), 1);
    chk("R3 overflow sticky", int'(overflow), 1);
  endtask

  task automatic t_underflow();
    logic [DW-1:0] held;
    held = out_sample;
    do_tick();
    chk("R7 underflow", int'(underflow), 1);
    chk("R7 held sample", int'(out_sample), int'(held));
  endtask

  task automatic t_disable();
    logic [DW-1:0] held;
    for (int i = 0; i < 5; i++) do_push(1);
    do_tick();
    do_tick();
    @(negedge clk);
    out_en = 0;
    @(negedge clk);
    chk("R8 flags cleared", int'({notify, missed, underflow, overflow}), 0);
    chk("R8 samples kept", int'(fill_level), 3);
    held = out_sample;
    do_tick();
    chk("R4 disabled tick sample", int'(out_sample), int'(held));
    chk("R4 disabled tick level", int'(fill_level), 3);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    mq.delete();
    chk("R9 flush fill", int'(fill_level), 0);
    out_en = 1;
    do_tick();
    chk("R9 tick after flush", int'(underflow), 1);
  endtask

  task automatic t_counter_restart();
    for (int i = 0; i < HALF; i++) do_push(1);
    for (int i = 0; i < HALF - 1; i++) do_tick();
    chk("R8 counter restarted", int'(notify), 0);
    do_tick();
    chk("R8 notify after fresh half", int'(notify), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_preload();
        t_overflow();
        t_notify();
        t_missed();
        t_underflow();
        t_disable();
        t_flush();
        t_counter_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule